// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a synthesizable slave for a two-wire serial bus that fronts a small byte array. A bus master selects it with a control byte, can set its internal address pointer, and can store single bytes into it. Reads come in three forms. A current address read returns the byte at the pointer. A random read first loads the pointer through a write header and then reads after a repeated START. A sequential read keeps streaming bytes for as long as the master acknowledges each one.

The data line is open-drain. The block never drives it high: it only pulls it low through `sda_oe_o` or lets it go. Both bus lines pass through a synchronizer to the system clock. The block samples incoming bits on rising SCL and changes its own drive only after falling SCL. A write-protect input blocks every store into the array but leaves reads as they are. One pointer serves every access mode, so an access always picks up where the previous one ended.

Top module: `twm_slave`

## Requirements
- R1: SDA is released (`sda_oe_o` = 0) after reset, and the block only ever asserts `sda_oe_o` (pull low) after a falling SCL, while SCL is low.
- R2: A control byte whose four most significant bits are 1010 is acknowledged whatever its next three bits are, and its least significant bit selects read (1) or write (0). Any other device code gets no acknowledge, and the block waits idle without touching the pointer.
- R3: A write transfer (control byte in write mode, then an address byte, then a data byte, each acknowledged) stores the data byte at that address on STOP and leaves the pointer at address + 1.
- R4: While `wp_i` is 1, write transfers are still acknowledged, but the array keeps its previous contents.
- R5: A random read returns the byte at the address sent in the write header that precedes the repeated START.
- R6: A current address read returns the byte at the pointer. Every byte sent advances the pointer by one, so the next current address read continues from the following address.
- R7: In a sequential read, each acknowledged byte is followed by the byte at the next address, and the address wraps from 0xFF to 0x00.
- R8: A START at any point abandons the transfer in progress, so a data byte received before it is never stored. A STOP releases SDA and returns the block to idle.
- R9: All array bytes read as 0x00 after reset.
- R10: After the eighth bit of a read byte, the block releases SDA for the master's acknowledge slot. A missing acknowledge (SDA high) ends the read, and SDA stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Resolved level of the serial data line |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| wp_i | input | 1 | Write protect: 1 blocks all stores into the array |

## Verification
Every bus event reaches the controller through two synchronizer flops and one edge-detect flop. The acknowledge or data drive therefore appears on `sda_oe_o` about four system clocks after SCL falls, and a stored byte takes effect about four clocks after the STOP edge. The bench holds each SCL phase for ten system clocks. It samples SDA only in the middle of the high phase, six or more clocks after the design has settled, and it reads stored bytes back through later bus reads rather than at a fixed cycle. Expected read bytes go into a queue before each read. A monitor compares each received byte in order as soon as the bus task delivers it.

// File: rtl/twm_pkg.sv
package twm_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_WAIT,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_RELOAD
    } state_e;

    typedef enum logic [1:0] {
        K_CTRL,
        K_ADDR,
        K_DATA
    } kind_e;
endpackage

// File: rtl/twm_line_sync.sv
module twm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] scl_pipe_q;
    logic [STAGES-1:0] sda_pipe_q;
    logic              scl_prev_q;
    logic              sda_prev_q;
    logic              scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_pipe_q <= {scl_pipe_q[TOP-1:0], scl_i};
            sda_pipe_q <= {sda_pipe_q[TOP-1:0], sda_i};
            scl_prev_q <= scl_pipe_q[TOP];
            sda_prev_q <= sda_pipe_q[TOP];
        end
    end

    assign scl_s    = scl_pipe_q[TOP];
    assign sda_s    = sda_pipe_q[TOP];
    assign scl_rise = !scl_prev_q && scl_s;
    assign scl_fall = scl_prev_q && !scl_s;
    assign start_ev = scl_prev_q && scl_s && sda_prev_q && !sda_s;
    assign stop_ev  = scl_prev_q && scl_s && !sda_prev_q && sda_s;
endmodule

// File: rtl/twm_array.sv
module twm_array #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/twm_slave.sv
module twm_slave
    import twm_pkg::*;
#(
    parameter int         ADDR_W      = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_CODE    = 4'b1010
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o,
    input  logic wp_i
);
    localparam int                 CNT_W    = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0]   LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        state_e            st;
        kind_e             kind;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic [ADDR_W-1:0] ptr;
        logic [BYTE_W-1:0] wdat;
        logic              pend;
        logic              rd;
        logic              oe;
    } regs_t;

    regs_t q, n;

    logic              sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic              mem_we;
    logic [BYTE_W-1:0] rdata;
    logic [BYTE_W-1:0] byte_in;
    logic              chk_idle, chk_mack;

    twm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    twm_array #(.AW(ADDR_W), .DW(BYTE_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (q.ptr),
        .wdata (q.wdat),
        .raddr (q.ptr),
        .rdata (rdata)
    );

    assign byte_in = {q.sh[BYTE_W-2:0], sda_s};

    always_comb begin
        n      = q;
        mem_we = 1'b0;
        if (start_ev) begin
            n.st   = ST_RX;
            n.kind = K_CTRL;
            n.cnt  = '0;
            n.oe   = 1'b0;
            n.pend = 1'b0;
        end else if (stop_ev) begin
            n.st   = ST_IDLE;
            n.oe   = 1'b0;
            n.pend = 1'b0;
            if (q.pend) begin
                mem_we = !wp_i;
                n.ptr  = q.ptr + 1'b1;
            end
        end else begin
            unique case (q.st)
                ST_RX: if (scl_rise) begin
                    n.sh  = byte_in;
                    n.cnt = q.cnt + 1'b1;
                    if (q.cnt == LAST_BIT) begin
                        n.cnt = '0;
                        n.st  = ST_ACK_WAIT;
                        unique case (q.kind)
                            K_CTRL: begin
                                n.rd = byte_in[0];
                                if (byte_in[BYTE_W-1 -: 4] != DEV_CODE) n.st = ST_IDLE;
                            end
                            K_ADDR: n.ptr = byte_in[ADDR_W-1:0];
                            default: begin
                                n.wdat = byte_in;
                                n.pend = 1'b1;
                            end
                        endcase
                    end
                end
                ST_ACK_WAIT: if (scl_fall) begin
                    n.oe = 1'b1;
                    n.st = ST_ACK;
                end
                ST_ACK: if (scl_fall) begin
                    n.oe  = 1'b0;
                    n.cnt = '0;
                    if (q.kind == K_CTRL && q.rd) begin
                        n.sh  = rdata;
                        n.oe  = !rdata[BYTE_W-1];
                        n.ptr = q.ptr + 1'b1;
                        n.st  = ST_TX;
                    end else if (q.kind == K_CTRL) begin
                        n.kind = K_ADDR;
                        n.st   = ST_RX;
                    end else if (q.kind == K_ADDR) begin
                        n.kind = K_DATA;
                        n.st   = ST_RX;
                    end else begin
                        n.st = ST_IDLE;
                    end
                end
                ST_TX: if (scl_fall) begin
                    if (q.cnt == LAST_BIT) begin
                        n.oe = 1'b0;
                        n.st = ST_MACK;
                    end else begin
                        n.cnt = q.cnt + 1'b1;
                        n.sh  = {q.sh[BYTE_W-2:0], 1'b0};
                        n.oe  = !q.sh[BYTE_W-2];
                    end
                end
                ST_MACK: if (scl_rise) begin
                    n.st = sda_s ? ST_IDLE : ST_RELOAD;
                end
                ST_RELOAD: if (scl_fall) begin
                    n.sh  = rdata;
                    n.oe  = !rdata[BYTE_W-1];
                    n.ptr = q.ptr + 1'b1;
                    n.cnt = '0;
                    n.st  = ST_TX;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.kind <= K_CTRL;
        end else begin
            q <= n;
        end
    end

    assign sda_oe_o = q.oe;
    assign chk_idle = (q.st == ST_IDLE);
    assign chk_mack = (q.st == ST_MACK);
endmodule

// File: rtl/twm_checker.sv
module twm_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe_o,
    input logic stop_ev,
    input logic mem_we,
    input logic wp_i,
    input logic chk_idle,
    input logic chk_mack
);
    AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_i); // R1
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe_o); // R8
    AST_WP_BLOCKS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        wp_i |-> !mem_we); // R4
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        chk_idle |-> !sda_oe_o); // R2
    AST_MACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        chk_mack |-> !sda_oe_o); // R10
endmodule

bind twm_slave twm_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe_o (sda_oe_o),
    .stop_ev  (stop_ev),
    .mem_we   (mem_we),
    .wp_i     (wp_i),
    .chk_idle (chk_idle),
    .chk_mack (chk_mack)
);

// File: tb/sim_twm_slave.sv
module sim_twm_slave;
    localparam int H = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic wp = 1'b0;
    logic oe;
    wire  sda_line = !(oe || m_low);

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_q [$];
    logic [7:0] act_q [$];
    string      tag_q [$];

    always #10 clk = !clk;

    twm_slave u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .sda_oe_o (oe),
        .wp_i     (wp)
    );

    task automatic hw(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    initial forever begin
        @(negedge clk);
        while (act_q.size() > 0) begin
            logic [7:0] a, e;
            string t;
            a = act_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (a !== e) begin
                n_bad++;
                $display("FAIL %s: read 0x%02h expected 0x%02h", t, a, e);
            end
        end
    end

    task automatic bus_start;
        if (!scl) begin
            m_low = 1'b0; hw(H);
            scl = 1'b1;   hw(H);
        end
        m_low = 1'b1; hw(H);
        scl = 1'b0;   hw(2);
    endtask

    task automatic bus_stop;
        m_low = 1'b1; hw(H);
        scl = 1'b1;   hw(H);
        m_low = 1'b0; hw(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            hw(2);
            m_low = !b[i];
            hw(H - 2);
            scl = 1'b1; hw(H);
            scl = 1'b0;
        end
        hw(2);
        m_low = 1'b0;
        hw(H - 2);
        scl = 1'b1; hw(H / 2);
        ack = !sda_line;
        hw(H / 2);
        scl = 1'b0;
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] d);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            hw(H);
            scl = 1'b1; hw(H / 2);
            d[i] = sda_line;
            hw(H / 2);
            scl = 1'b0;
        end
        hw(2);
        m_low = give_ack;
        hw(H - 2);
        scl = 1'b1; hw(H);
        scl = 1'b0; hw(2);
        m_low = 1'b0;
    endtask

    task automatic do_write(input string req, input logic [7:0] a, input logic [7:0] d);
        logic ack;
        bus_start();
        send_byte(8'hA0, ack); check_bit({req, " ctrl ack"}, ack, 1'b1);
        send_byte(a, ack);     check_bit({req, " addr ack"}, ack, 1'b1);
        send_byte(d, ack);     check_bit({req, " data ack"}, ack, 1'b1);
        bus_stop();
    endtask

    task automatic rand_read(input string req, input logic [7:0] a,
                             input logic [7:0] e0, input logic [7:0] e1,
                             input logic [7:0] e2, input logic [7:0] e3, input int cnt);
        logic ack;
        logic [7:0] d;
        logic [7:0] ev [4];
        ev[0] = e0; ev[1] = e1; ev[2] = e2; ev[3] = e3;
        bus_start();
        send_byte(8'hA0, ack); check_bit({req, " hdr ack"}, ack, 1'b1);
        send_byte(a, ack);     check_bit({req, " addr ack"}, ack, 1'b1);
        bus_start();
        send_byte(8'hA1, ack); check_bit({req, " rd ctrl ack"}, ack, 1'b1);
        for (int k = 0; k < cnt; k++) begin
            exp_q.push_back(ev[k]);
            tag_q.push_back(req);
            read_byte(k != cnt - 1, d);
            act_q.push_back(d);
        end
        bus_stop();
    endtask

    task automatic cur_read(input string req, input logic [7:0] ctrl, input logic [7:0] e);
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte(ctrl, ack); check_bit({req, " ctrl ack"}, ack, 1'b1);
        exp_q.push_back(e);
        tag_q.push_back(req);
        read_byte(1'b0, d);
        act_q.push_back(d);
        hw(4);
        check_bit("R10 released after nack", oe, 1'b0);
        bus_stop();
    endtask

    initial begin
        logic ack;
        hw(5);
        check_bit("R1 reset release", oe, 1'b0);
        rst_n = 1'b1;
        hw(5);
        check_bit("R1 idle release", oe, 1'b0);

        rand_read("R9", 8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 1);

        do_write("R3", 8'h10, 8'h5A);
        do_write("R3", 8'h11, 8'hC3);
        do_write("R3", 8'hFF, 8'h7E);
        do_write("R3", 8'h00, 8'h81);
        // R3: pointer now 0x01, a current read returns mem[0x01] = 0
        cur_read("R3 ptr", 8'hA1, 8'h00);

        rand_read("R5", 8'h10, 8'h5A, 8'h00, 8'h00, 8'h00, 1);
        cur_read("R6", 8'hA1, 8'hC3);
        cur_read("R6", 8'hAF, 8'h00);

        rand_read("R7", 8'hFE, 8'h00, 8'h7E, 8'h81, 8'h00, 4);

        wp = 1'b1;
        do_write("R4", 8'h10, 8'hAA);
        wp = 1'b0;
        rand_read("R4", 8'h10, 8'h5A, 8'h00, 8'h00, 8'h00, 1);

        bus_start();
        send_byte(8'h90, ack); check_bit("R2 foreign code nack", ack, 1'b0);
        bus_stop();
        cur_read("R2 ptr kept", 8'hA1, 8'hC3);

        bus_start();
        send_byte(8'hA0, ack); check_bit("R8 ctrl ack", ack, 1'b1);
        send_byte(8'h20, ack); check_bit("R8 addr ack", ack, 1'b1);
        send_byte(8'h33, ack); check_bit("R8 data ack", ack, 1'b1);
        bus_start();
        bus_stop();
        check_bit("R8 stop release", oe, 1'b0);
        rand_read("R8", 8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 1);

        hw(20);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule